// File: doc/BRIEF.md
# Packed SIMD Add/Subtract Unit with Lane Flags

This block performs arithmetic on one 32-bit word that is split into lanes. The word can be four 8-bit lanes or two 16-bit lanes. Each lane is added or subtracted on its own, with no carry crossing a lane boundary. Alongside the result, the block keeps a 4-bit register with one "greater-or-equal" flag per byte. How a flag is set depends on the selected mode, signed or unsigned. A later select operation reads these flags and builds a new word byte by byte from two operands. This lets software run a lane-wise compare, followed by a merge, with no branches.

The same single stage also handles operand shaping. Two halfword pack forms take one half from each operand, and the operand that supplies the moving half can be shifted by 0 to 31 bits first. An unpack form widens bytes 0 and 2 into halfwords. Each accepted operation is registered once. Its result, its flags and a valid strobe appear one cycle after the operation is presented.

Top module: `simd_ge_unit`

## Requirements
- R1: While `rst_n` is low, `result`, `ge_flags` and `result_valid` are all zero.
- R2: Opcode 3'b000 adds and 3'b001 subtracts four independent byte lanes (byte i is bits 8i+7..8i). Each lane wraps modulo 256, and no carry or borrow crosses a byte boundary.
- R3: Opcode 3'b010 adds and 3'b011 subtracts two independent halfword lanes (bits 15..0 and 31..16). Each lane wraps modulo 65536.
- R4: With `signed_mode`=0, a lane's flag is 1 on carry-out for an add, and 1 when no borrow occurs for a subtract (a ≥ b).
- R5: With `signed_mode`=1, a lane's flag is 1 exactly when the true, unwrapped signed sum or difference is ≥ 0.
- R6: For a halfword operation, the flag of halfword h is written to both `ge_flags[2h]` and `ge_flags[2h+1]`.
- R7: Opcode 3'b100 (select) sets result byte i to `src_a` byte i when `ge_flags[i]`=1, and to `src_b` byte i otherwise. It uses the flag register as it stood before the operation. The flags are not changed.
- R8: Opcode 3'b101 returns {`src_a`[31:16], (`src_b` << `shamt`)[15:0]}, a logical left shift.
- R9: Opcode 3'b110 returns {(`src_b` >>> `shamt`)[31:16], `src_a`[15:0]}, an arithmetic right shift.
- R10: Opcode 3'b111 returns {ext(`src_a`[23:16]), ext(`src_a`[7:0])}. Each ext widens a byte to 16 bits, sign-extending when `signed_mode`=1 and zero-extending otherwise.
- R11: An operation presented with `in_valid`=1 shows up on the outputs after the next clock edge, with `result_valid`=1. A cycle with `in_valid`=0 drives `result_valid` to 0 and leaves `result` and `ge_flags` unchanged.
- R12: Opcodes 3'b100 to 3'b111 leave `ge_flags` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| opcode | input | 3 | Operation code (see requirements) |
| signed_mode | input | 1 | 1 = signed lanes / sign-extending unpack |
| src_a | input | 32 | First operand |
| src_b | input | 32 | Second operand |
| shamt | input | 5 | Shift amount for the pack forms |
| result | output | 32 | Registered result word |
| ge_flags | output | 4 | Registered per-byte greater-or-equal flags |
| result_valid | output | 1 | Result registered from a valid operation |

## Verification
The key collision happens when an arithmetic operation is followed on the very next cycle by a select. At one clock edge, the flag register is being written by the arithmetic and read by the select that follows it, so the select must see the flags that were just produced. The bench issues lane additions and subtractions with operands chosen so that some lanes carry and some do not, then issues a select right after them. It compares each merged byte with a reference model that keeps its own flag state. The reverse order is also checked: an arithmetic op issued right after a select must not pick up stale flags.

// File: rtl/simd_pkg.sv
package simd_pkg;

    localparam int WORD_W    = 32;
    localparam int BYTE_W    = 8;
    localparam int HALF_W    = 2 * BYTE_W;
    localparam int NUM_BYTES = WORD_W / BYTE_W;
    localparam int NUM_HALVES = WORD_W / HALF_W;
    localparam int SH_W      = $clog2(WORD_W);
    localparam int OP_W      = 3;

    typedef enum logic [OP_W-1:0] {
        OP_ADD8  = 3'b000,
        OP_SUB8  = 3'b001,
        OP_ADD16 = 3'b010,
        OP_SUB16 = 3'b011,
        OP_SEL   = 3'b100,
        OP_PKLO  = 3'b101,
        OP_PKHI  = 3'b110,
        OP_UNPK  = 3'b111
    } simd_op_e;

    typedef struct packed {
        logic [WORD_W-1:0]    res;
        logic [NUM_BYTES-1:0] ge;
        logic                 vld;
    } simd_state_t;

endpackage

// File: rtl/simd_lane_addsub.sv
module simd_lane_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         do_sub,
    input  logic         is_signed,
    output logic [W-1:0] sum,
    output logic         ge
);
    logic [W:0] ax;
    logic [W:0] bx;
    logic [W:0] x;

    always_comb begin
        // one guard bit: exact result fits in W+1 bits for both modes
        ax  = {is_signed & a[W-1], a};
        bx  = {is_signed & b[W-1], b};
        x   = do_sub ? (ax - bx) : (ax + bx);
        sum = x[W-1:0];
        // unsigned add: guard bit is the carry; otherwise guard bit is the sign
        ge  = (do_sub | is_signed) ? ~x[W] : x[W];
    end
endmodule

// File: rtl/simd_byte_select.sv
module simd_byte_select
    import simd_pkg::*;
(
    input  logic [WORD_W-1:0]    a,
    input  logic [WORD_W-1:0]    b,
    input  logic [NUM_BYTES-1:0] pick_a,
    output logic [WORD_W-1:0]    merged
);
    for (genvar i = 0; i < NUM_BYTES; i++) begin : g_byte
        assign merged[i*BYTE_W +: BYTE_W] =
            pick_a[i] ? a[i*BYTE_W +: BYTE_W] : b[i*BYTE_W +: BYTE_W];
    end
endmodule

// File: rtl/simd_pack_unit.sv
module simd_pack_unit
    import simd_pkg::*;
(
    input  logic [WORD_W-1:0] a,
    input  logic [WORD_W-1:0] b,
    input  logic [SH_W-1:0]   shamt,
    input  simd_op_e          op,
    input  logic              is_signed,
    output logic [WORD_W-1:0] packed_out
);
    logic [HALF_W-1:0] b_lo_shl;
    logic [HALF_W-1:0] b_hi_sra;
    logic [HALF_W-1:0] ext_lo;
    logic [HALF_W-1:0] ext_hi;

    always_comb begin
        b_lo_shl = HALF_W'(b << shamt);
        // upper half of (b >>> shamt) equals low half of b >>> (shamt + HALF_W)
        b_hi_sra = HALF_W'($signed(b) >>> (int'(shamt) + HALF_W));
        ext_lo   = {{(HALF_W-BYTE_W){is_signed & a[BYTE_W-1]}}, a[BYTE_W-1:0]};
        ext_hi   = {{(HALF_W-BYTE_W){is_signed & a[HALF_W+BYTE_W-1]}},
                    a[HALF_W +: BYTE_W]};
        unique case (op)
            OP_PKLO: packed_out = {a[WORD_W-1:HALF_W], b_lo_shl};
            OP_PKHI: packed_out = {b_hi_sra, a[HALF_W-1:0]};
            default: packed_out = {ext_hi, ext_lo};
        endcase
    end
endmodule

// File: rtl/simd_ge_unit.sv
module simd_ge_unit
    import simd_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [OP_W-1:0]       opcode,
    input  logic                  signed_mode,
    input  logic [WORD_W-1:0]     src_a,
    input  logic [WORD_W-1:0]     src_b,
    input  logic [SH_W-1:0]       shamt,
    output logic [WORD_W-1:0]     result,
    output logic [NUM_BYTES-1:0]  ge_flags,
    output logic                  result_valid
);
    simd_op_e             op;
    simd_state_t          st_d, st_q;
    logic [WORD_W-1:0]    byte_sum, half_sum, sel_out, pack_out;
    logic [NUM_BYTES-1:0] byte_ge, half_ge_x;
    logic [NUM_HALVES-1:0] half_ge;

    assign op = simd_op_e'(opcode);

    for (genvar i = 0; i < NUM_BYTES; i++) begin : g_byte_lane
        simd_lane_addsub #(.W(BYTE_W)) u_lane (
            .a         (src_a[i*BYTE_W +: BYTE_W]),
            .b         (src_b[i*BYTE_W +: BYTE_W]),
            .do_sub    (opcode[0]),
            .is_signed (signed_mode),
            .sum       (byte_sum[i*BYTE_W +: BYTE_W]),
            .ge        (byte_ge[i])
        );
    end

    for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half_lane
        simd_lane_addsub #(.W(HALF_W)) u_lane (
            .a         (src_a[h*HALF_W +: HALF_W]),
            .b         (src_b[h*HALF_W +: HALF_W]),
            .do_sub    (opcode[0]),
            .is_signed (signed_mode),
            .sum       (half_sum[h*HALF_W +: HALF_W]),
            .ge        (half_ge[h])
        );
        assign half_ge_x[2*h +: 2] = {2{half_ge[h]}};
    end

    simd_byte_select u_sel (
        .a      (src_a),
        .b      (src_b),
        .pick_a (st_q.ge),
        .merged (sel_out)
    );

    simd_pack_unit u_pack (
        .a          (src_a),
        .b          (src_b),
        .shamt      (shamt),
        .op         (op),
        .is_signed  (signed_mode),
        .packed_out (pack_out)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            unique case (op)
                OP_ADD8, OP_SUB8: begin
                    st_d.res = byte_sum;
                    st_d.ge  = byte_ge;
                end
                OP_ADD16, OP_SUB16: begin
                    st_d.res = half_sum;
                    st_d.ge  = half_ge_x;
                end
                OP_SEL:  st_d.res = sel_out;
                default: st_d.res = pack_out;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign result       = st_q.res;
    assign ge_flags     = st_q.ge;
    assign result_valid = st_q.vld;
endmodule

// File: rtl/simd_ge_unit_chk.sv
module simd_ge_unit_chk
    import simd_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic [OP_W-1:0]      opcode,
    input logic                 signed_mode,
    input logic [WORD_W-1:0]    src_a,
    input logic [WORD_W-1:0]    src_b,
    input logic [WORD_W-1:0]    result,
    input logic [NUM_BYTES-1:0] ge_flags,
    input logic                 result_valid
);
    logic [WORD_W-1:0] merge_ref;
    logic [BYTE_W:0]   low_usum;

    always_comb begin
        for (int i = 0; i < NUM_BYTES; i++)
            merge_ref[i*BYTE_W +: BYTE_W] = ge_flags[i] ? src_a[i*BYTE_W +: BYTE_W]
                                                        : src_b[i*BYTE_W +: BYTE_W];
        low_usum = {1'b0, src_a[BYTE_W-1:0]} + {1'b0, src_b[BYTE_W-1:0]};
    end

    p_reset_zero_r1: assert property (@(posedge clk)
        !rst_n |=> (result == '0 && ge_flags == '0 && !result_valid));

    p_valid_follow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> result_valid);

    p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!result_valid && $stable(result) && $stable(ge_flags)));

    p_half_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode[2:1] == 2'b01) |=>
            (ge_flags[1] == ge_flags[0] && ge_flags[3] == ge_flags[2]));

    p_ge_keep_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode[2]) |=> $stable(ge_flags));

    p_select_merge_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode == 3'b100) |=> (result == $past(merge_ref)));

    p_pack_upper_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode == 3'b101) |=> (result[31:16] == $past(src_a[31:16])));

    p_pack_lower_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode == 3'b110) |=> (result[15:0] == $past(src_a[15:0])));

    p_carry_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode == 3'b000 && !signed_mode) |=>
            (ge_flags[0] == $past(low_usum[BYTE_W])));
endmodule

bind simd_ge_unit simd_ge_unit_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .opcode       (opcode),
    .signed_mode  (signed_mode),
    .src_a        (src_a),
    .src_b        (src_b),
    .result       (result),
    .ge_flags     (ge_flags),
    .result_valid (result_valid)
);

// File: tb/tb_simd_ge_unit.sv
module tb_simd_ge_unit;
    logic        clk = 1'b0;
    logic        rst_n, in_valid, signed_mode;
    logic [2:0]  opcode;
    logic [31:0] src_a, src_b, result;
    logic [4:0]  shamt;
    logic [3:0]  ge_flags;
    logic        result_valid;

    always #5 clk = ~clk;

    simd_ge_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
        .signed_mode(signed_mode), .src_a(src_a), .src_b(src_b), .shamt(shamt),
        .result(result), .ge_flags(ge_flags), .result_valid(result_valid)
    );

    int checks = 0, fails = 0;
    bit done = 0;
    logic [31:0] m_res;
    logic [3:0]  m_ge;
    logic        m_vld;
    string       cur_tag, m_tag;

    // behavioural reference: lanes as integers
    task automatic model_op(input logic [2:0] op, input logic [31:0] a, b,
                            input logic sg, input logic [4:0] sh,
                            input logic [3:0] gin,
                            output logic [31:0] r, output logic [3:0] g);
        int lw, n, x, y, z;
        r = '0; g = gin;
        if (op < 3'd4) begin
            lw = (op >= 3'd2) ? 16 : 8;
            n  = 32 / lw;
            for (int i = 0; i < n; i++) begin
                x = int'((a >> (i*lw)) & ((1 << lw) - 1));
                y = int'((b >> (i*lw)) & ((1 << lw) - 1));
                if (sg) begin
                    if (x >= (1 << (lw-1))) x = x - (1 << lw);
                    if (y >= (1 << (lw-1))) y = y - (1 << lw);
                end
                z = op[0] ? x - y : x + y;
                r = r | ((32'(z) & ((32'd1 << lw) - 1)) << (i*lw));
                for (int k = 0; k < lw/8; k++)
                    g[i*(lw/8)+k] = (!sg && !op[0]) ? (z >= (1 << lw)) : (z >= 0);
            end
        end else if (op == 3'd4) begin
            for (int i = 0; i < 4; i++)
                r[i*8 +: 8] = gin[i] ? a[i*8 +: 8] : b[i*8 +: 8];
        end else if (op == 3'd5) begin
            r = {a[31:16], 16'(b << sh)};
        end else if (op == 3'd6) begin
            x = int'(b) >>> sh;
            r = {16'(x >>> 16), a[15:0]};
        end else begin
            x = sg ? int'($signed(a[23:16])) : int'(a[23:16]);
            y = sg ? int'($signed(a[7:0])) : int'(a[7:0]);
            r = {16'(x), 16'(y)};
        end
    endtask

    always @(posedge clk) begin
        logic [31:0] r;
        logic [3:0]  g;
        if (!rst_n) begin
            m_res <= '0; m_ge <= '0; m_vld <= 1'b0; m_tag <= "R1";
        end else if (in_valid) begin
            model_op(opcode, src_a, src_b, signed_mode, shamt, m_ge, r, g);
            m_res <= r; m_ge <= g; m_vld <= 1'b1; m_tag <= cur_tag;
        end else begin
            m_vld <= 1'b0; m_tag <= "R11";
        end
    end

    task automatic compare();
        checks++;
        if (result !== m_res || ge_flags !== m_ge || result_valid !== m_vld) begin
            fails++;
            $display("FAIL %s: result=%h ge=%b vld=%b expected result=%h ge=%b vld=%b",
                     m_tag, result, ge_flags, result_valid, m_res, m_ge, m_vld);
        end
    endtask

    function automatic string tag_of(input logic [2:0] op, input logic sg);
        case (op)
            3'd0, 3'd1: return sg ? "R2,R5" : "R2,R4";
            3'd2, 3'd3: return sg ? "R3,R5,R6" : "R3,R4,R6";
            3'd4: return "R7,R12";
            3'd5: return "R8,R12";
            3'd6: return "R9,R12";
            default: return "R10,R12";
        endcase
    endfunction

    task automatic issue(input logic [2:0] op, input logic [31:0] a, b,
                         input logic sg, input logic [4:0] sh);
        @(negedge clk);
        compare();
        in_valid = 1'b1; opcode = op; src_a = a; src_b = b;
        signed_mode = sg; shamt = sh; cur_tag = tag_of(op, sg);
    endtask

    task automatic idle(input logic [31:0] junk);
        @(negedge clk);
        compare();
        in_valid = 1'b0; opcode = junk[2:0]; src_a = junk; src_b = ~junk;
        signed_mode = junk[3]; shamt = junk[8:4];
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: expired, expected completion");
        finish_run();
    end

    initial begin
        rst_n = 0; in_valid = 0; opcode = 0; signed_mode = 0;
        src_a = 0; src_b = 0; shamt = 0; cur_tag = "R1";
        repeat (3) @(negedge clk);
        // R1: explicit reset values
        checks++;
        if (result !== 32'h0 || ge_flags !== 4'h0 || result_valid !== 1'b0) begin
            fails++;
            $display("FAIL R1: result=%h ge=%b vld=%b expected 0 0 0",
                     result, ge_flags, result_valid);
        end
        rst_n = 1;
        // byte carries in lanes 0,1,3 but not 2 (R2, R4), then select right after
        issue(3'd0, 32'hFF01_80FF, 32'h0101_8001, 1'b0, 5'd0);
        issue(3'd4, 32'hAAAA_AAAA, 32'h5555_5555, 1'b0, 5'd0);
        // arithmetic right after select must use fresh operands
        issue(3'd1, 32'h0010_7F80, 32'h0020_8001, 1'b1, 5'd0);
        issue(3'd4, 32'h1122_3344, 32'h5566_7788, 1'b0, 5'd0);
        issue(3'd3, 32'h1234_0000, 32'h1234_0001, 1'b0, 5'd0);
        issue(3'd2, 32'h8000_7FFF, 32'hFFFF_0001, 1'b1, 5'd0);
        issue(3'd4, 32'hDEAD_BEEF, 32'h0123_4567, 1'b1, 5'd0);
        issue(3'd1, 32'h0000_0000, 32'h0000_0000, 1'b0, 5'd0);
        issue(3'd5, 32'hCAFE_F00D, 32'h8765_4321, 1'b0, 5'd0);
        issue(3'd5, 32'hCAFE_F00D, 32'h8765_4321, 1'b0, 5'd31);
        issue(3'd6, 32'h1357_2468, 32'h8765_4321, 1'b0, 5'd0);
        issue(3'd6, 32'h1357_2468, 32'h8765_4321, 1'b0, 5'd16);
        issue(3'd6, 32'h1357_2468, 32'h8000_0000, 1'b0, 5'd31);
        issue(3'd7, 32'h0080_00FF, 32'h0, 1'b1, 5'd0);
        issue(3'd7, 32'h0080_00FF, 32'h0, 1'b0, 5'd0);
        idle(32'hFFFF_FFFF);
        idle(32'h0F0F_0F0F);
        for (int i = 0; i < 600; i++) begin
            if (($urandom % 5) == 0) idle($urandom);
            else issue(3'($urandom), $urandom, $urandom, 1'($urandom), 5'($urandom));
        end
        idle(32'h0);
        @(negedge clk);
        compare();
        finish_run();
    end
endmodule